// File: doc/BRIEF.md
# Daughterboard Pin Controller with Radio-State Source Selection

This block drives a bank of daughterboard I/O pins that is split into two equal halves: a transmit-side half in the upper bits and a receive-side half in the lower bits. Software sets a direction bit for every pin. For every output pin it also picks one of four sources: a software data bit, the automatic radio-state value, or one bit of either of two debug buses.

The automatic value comes from a bank of eight words, one per radio state and side. The radio state is taken from two status inputs and registered once, so pins that follow the radio state switch without any software action. Software uses a simple register write port and a registered read port. Reading the data address returns the sampled pad levels, not the software data register.

Top module: `dbio_pin_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the direction, data, both select and all eight state words read as zero, pad_oe and pad_out are zero, and rd_data is zero.
- R2: pad_oe equals the direction register (address 0x00, 1 = output), with bits 31:16 for the transmit side and 15:0 for the receive side. A write is visible on pad_oe after the write's clock edge.
- R3: An output pin with select code 0 drives the matching bit of the data register (address 0x04).
- R4: An output pin with select code 1 drives bit p of the state word for its own side and the current radio state, where p is the pin's index within its side.
- R5: An output pin with select code 2 drives the same-index bit of dbg0. Code 3 drives the same-index bit of dbg1.
- R6: A pin whose direction bit is 0 has pad_out low, whatever its select code or data.
- R7: The radio state is {rx_active, tx_active}: 0 idle, 1 transmit only, 2 receive only, 3 full duplex. A status change reaches pad_out on the first clock edge after it, and not before.
- R8: The state word for state s and side k is at byte address 0x10 + 4*s + 2*k, with k = 0 for the transmit side and k = 1 for the receive side. It takes wr_data[15:0] and reads back zero-extended.
- R9: A read of address 0x04 returns pad_in as sampled by a clock edge. rd_data shows a pad level two clock edges after that level is applied. The transmit side is in bits 31:16 and the receive side in bits 15:0.
- R10: The direction (0x00), receive select (0x08) and transmit select (0x0C) registers read back as written. Writes to unmapped addresses, including every odd address, change no register and no output. Reads of unmapped addresses return zero.
- R11: Each select register holds sixteen 2-bit codes, with pin p at bits 2p+1:2p. Address 0x0C serves the transmit side and 0x08 serves the receive side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Byte address for the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 5 | Byte address for the registered read |
| rd_data | output | 32 | Read data, one edge after rd_addr |
| tx_active | input | 1 | Radio is transmitting |
| rx_active | input | 1 | Radio is receiving |
| dbg0 | input | 32 | Debug bus 0, one bit per pin |
| dbg1 | input | 32 | Debug bus 1, one bit per pin |
| pad_in | input | 32 | Pad levels to sample |
| pad_out | output | 32 | Pad output values |
| pad_oe | output | 32 | Pad output enables |

## Verification
The assertions assume that pad_in, the status inputs and the write port change only away from the rising edge, and that a pad level is held for the cycles between sampling and readback. The bench drives every input on the falling edge and holds pad_in steady across each read. It sweeps every radio state against uniform and mixed select patterns and against several direction masks, and computes each expected pin from its own model of the registers.

// File: rtl/dbio_pkg.sv
`timescale 1ns/1ps
// Package: shared encodings and the address layout of the pin controller.
// Assumes byte addressing with 32-bit registers on word boundaries and
// 16-bit radio-state words on half-word boundaries.
package dbio_pkg;

    // Radio state, built as {rx_active, tx_active}.
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_TX_ONLY = 2'd1,
        ST_RX_ONLY = 2'd2,
        ST_FULL    = 2'd3
    } radio_state_e;

    // Per-pin output source code.
    typedef enum logic [1:0] {
        SRC_SW   = 2'd0,
        SRC_ATR  = 2'd1,
        SRC_DBG0 = 2'd2,
        SRC_DBG1 = 2'd3
    } pin_src_e;

    // Byte offsets of the registers.
    localparam int unsigned OFS_DIR    = 0;
    localparam int unsigned OFS_DATA   = 4;
    localparam int unsigned OFS_SEL_RX = 8;
    localparam int unsigned OFS_SEL_TX = 12;
    localparam int unsigned OFS_ATR    = 16;

    // Four radio states times two sides.
    localparam int unsigned NUM_ATR = 8;

    // Decoded address.
    typedef struct packed {
        logic       dir;
        logic       data;
        logic       sel_rx;
        logic       sel_tx;
        logic       atr;
        logic [2:0] idx;
    } addr_dec_t;

endpackage

// File: rtl/dbio_regfile.sv
`timescale 1ns/1ps
// Module: dbio_regfile
// Holds the direction, data, two select and eight radio-state registers.
// It also samples the pads and serves a registered read port.
// Assumes: ADDR_W is 5 (registers at 0x00..0x0C, state words at
// 0x10..0x1E). Accesses to any other address are ignored or read as zero.
module dbio_regfile
    import dbio_pkg::*;
#(
    parameter int unsigned SIDE_W = 16,
    parameter int unsigned ADDR_W = 5
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                wr_en,
    input  logic [ADDR_W-1:0]                   wr_addr,
    input  logic [2*SIDE_W-1:0]                 wr_data,
    input  logic [ADDR_W-1:0]                   rd_addr,
    output logic [2*SIDE_W-1:0]                 rd_data,
    input  logic [2*SIDE_W-1:0]                 pad_in,
    output logic [2*SIDE_W-1:0]                 dir_q,
    output logic [2*SIDE_W-1:0]                 data_q,
    output logic [2*SIDE_W-1:0]                 sel_rx_q,
    output logic [2*SIDE_W-1:0]                 sel_tx_q,
    output logic [NUM_ATR-1:0][SIDE_W-1:0]      atr_q
);

    localparam int unsigned BUS_W = 2 * SIDE_W;
    localparam logic [ADDR_W-1:0] AD_DIR    = ADDR_W'(OFS_DIR);
    localparam logic [ADDR_W-1:0] AD_DATA   = ADDR_W'(OFS_DATA);
    localparam logic [ADDR_W-1:0] AD_SEL_RX = ADDR_W'(OFS_SEL_RX);
    localparam logic [ADDR_W-1:0] AD_SEL_TX = ADDR_W'(OFS_SEL_TX);
    localparam logic [ADDR_W-5:0] AD_ATR_HI = (ADDR_W-4)'(OFS_ATR >> 4);

    logic [BUS_W-1:0] pins_q;
    logic [BUS_W-1:0] rd_next;
    addr_dec_t        wdec;
    addr_dec_t        rdec;

    // Decode one byte address into register hits.
    function automatic addr_dec_t decode(input logic [ADDR_W-1:0] a);
        addr_dec_t d;
        d.dir    = (a == AD_DIR);
        d.data   = (a == AD_DATA);
        d.sel_rx = (a == AD_SEL_RX);
        d.sel_tx = (a == AD_SEL_TX);
        d.atr    = (a[ADDR_W-1:4] == AD_ATR_HI) && !a[0];
        d.idx    = a[3:1];
        return d;
    endfunction

    // Decode the write and read addresses.
    always_comb begin
        wdec = decode(wr_addr);
        rdec = decode(rd_addr);
    end

    // Update the control registers on a write to a mapped address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q    <= '0;
            data_q   <= '0;
            sel_rx_q <= '0;
            sel_tx_q <= '0;
            atr_q    <= '0;
        end else if (wr_en) begin
            if (wdec.dir)    dir_q    <= wr_data;
            if (wdec.data)   data_q   <= wr_data;
            if (wdec.sel_rx) sel_rx_q <= wr_data;
            if (wdec.sel_tx) sel_tx_q <= wr_data;
            if (wdec.atr)    atr_q[wdec.idx] <= wr_data[SIDE_W-1:0];
        end
    end

    // Sample the pad levels once per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) pins_q <= '0;
        else        pins_q <= pad_in;
    end

    // Select the read value; the data address returns the sampled pads.
    always_comb begin
        rd_next = '0;
        if (rdec.dir)    rd_next = dir_q;
        if (rdec.data)   rd_next = pins_q;
        if (rdec.sel_rx) rd_next = sel_rx_q;
        if (rdec.sel_tx) rd_next = sel_tx_q;
        if (rdec.atr)    rd_next = BUS_W'(atr_q[rdec.idx]);
    end

    // Register the read data.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_data <= '0;
        else        rd_data <= rd_next;
    end

    AST_DIR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == AD_DIR) |=> dir_q == $past(wr_data)); // R2

    AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr == AD_DIR) |=> $stable(dir_q)); // R2

    AST_ODD_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr[0]) |=> ($stable(dir_q) && $stable(data_q) &&
            $stable(sel_rx_q) && $stable(sel_tx_q) && $stable(atr_q))); // R10

endmodule

// File: rtl/dbio_atr_sel.sv
`timescale 1ns/1ps
// Module: dbio_atr_sel
// Registers the radio state from the two status inputs and picks the
// state word for each side from the bank.
// Assumes: bank entry {state, side} holds the word, with side 0 for the
// transmit side and side 1 for the receive side.
module dbio_atr_sel
    import dbio_pkg::*;
#(
    parameter int unsigned SIDE_W = 16
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           tx_active,
    input  logic                           rx_active,
    input  logic [NUM_ATR-1:0][SIDE_W-1:0] atr_bank,
    output logic [SIDE_W-1:0]              atr_tx_word,
    output logic [SIDE_W-1:0]              atr_rx_word
);

    radio_state_e state_q;

    // Capture the radio state one edge after the status inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= radio_state_e'({rx_active, tx_active});
    end

    // Pick the word of each side for the current state.
    always_comb begin
        atr_tx_word = atr_bank[{state_q, 1'b0}];
        atr_rx_word = atr_bank[{state_q, 1'b1}];
    end

    AST_STATE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_active && !rx_active) |=> state_q == ST_IDLE); // R7

    AST_STATE_TX: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_active && !rx_active) |=> state_q == ST_TX_ONLY); // R7

    AST_STATE_RX: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_active && rx_active) |=> state_q == ST_RX_ONLY); // R7

    AST_STATE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_active && rx_active) |=> state_q == ST_FULL); // R7

    AST_WORD_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(state_q) && $stable(atr_bank)) |-> $stable(atr_tx_word)); // R4

endmodule

// File: rtl/dbio_pin_mux.sv
`timescale 1ns/1ps
// Module: dbio_pin_mux
// Picks the output source of each pin of one side and gates it with the
// pin's direction bit.
// Assumes: pin p's select code sits in sel[2p+1:2p].
module dbio_pin_mux
    import dbio_pkg::*;
#(
    parameter int unsigned SIDE_W = 16
) (
    input  logic [SIDE_W-1:0]   dir,
    input  logic [SIDE_W-1:0]   sw_data,
    input  logic [2*SIDE_W-1:0] sel,
    input  logic [SIDE_W-1:0]   atr_word,
    input  logic [SIDE_W-1:0]   dbg0,
    input  logic [SIDE_W-1:0]   dbg1,
    output logic [SIDE_W-1:0]   pin_out
);

    for (genvar p = 0; p < SIDE_W; p++) begin : g_pin
        pin_src_e code;
        logic     value;

        assign code = pin_src_e'(sel[2*p +: 2]);

        // Pick this pin's source and drive it only when it is an output.
        always_comb begin
            unique case (code)
                SRC_SW:   value = sw_data[p];
                SRC_ATR:  value = atr_word[p];
                SRC_DBG0: value = dbg0[p];
                SRC_DBG1: value = dbg1[p];
            endcase
            pin_out[p] = dir[p] & value;
        end
    end

endmodule

// File: rtl/dbio_pin_ctrl.sv
`timescale 1ns/1ps
// Module: dbio_pin_ctrl (top)
// Daughterboard pin controller: the register bank, the radio-state word
// selection and one pin multiplexer per side.
// Assumes: side 1 (upper half of the bus) is the transmit side and side 0
// (lower half) is the receive side. Pad cells are outside this block.
module dbio_pin_ctrl
    import dbio_pkg::*;
#(
    parameter int unsigned SIDE_W = 16,
    parameter int unsigned ADDR_W = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [2*SIDE_W-1:0]   wr_data,
    input  logic [ADDR_W-1:0]     rd_addr,
    output logic [2*SIDE_W-1:0]   rd_data,
    input  logic                  tx_active,
    input  logic                  rx_active,
    input  logic [2*SIDE_W-1:0]   dbg0,
    input  logic [2*SIDE_W-1:0]   dbg1,
    input  logic [2*SIDE_W-1:0]   pad_in,
    output logic [2*SIDE_W-1:0]   pad_out,
    output logic [2*SIDE_W-1:0]   pad_oe
);

    localparam int unsigned BUS_W = 2 * SIDE_W;

    logic [BUS_W-1:0]                dir_q;
    logic [BUS_W-1:0]                data_q;
    logic [BUS_W-1:0]                sel_rx_q;
    logic [BUS_W-1:0]                sel_tx_q;
    logic [NUM_ATR-1:0][SIDE_W-1:0]  atr_q;
    logic [SIDE_W-1:0]               atr_tx_word;
    logic [SIDE_W-1:0]               atr_rx_word;

    dbio_regfile #(.SIDE_W(SIDE_W), .ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .pad_in   (pad_in),
        .dir_q    (dir_q),
        .data_q   (data_q),
        .sel_rx_q (sel_rx_q),
        .sel_tx_q (sel_tx_q),
        .atr_q    (atr_q)
    );

    dbio_atr_sel #(.SIDE_W(SIDE_W)) u_atr (
        .clk         (clk),
        .rst_n       (rst_n),
        .tx_active   (tx_active),
        .rx_active   (rx_active),
        .atr_bank    (atr_q),
        .atr_tx_word (atr_tx_word),
        .atr_rx_word (atr_rx_word)
    );

    // One multiplexer per side; side 1 is the transmit half.
    for (genvar s = 0; s < 2; s++) begin : g_side
        localparam int unsigned LO = s * SIDE_W;
        dbio_pin_mux #(.SIDE_W(SIDE_W)) u_mux (
            .dir      (dir_q[LO +: SIDE_W]),
            .sw_data  (data_q[LO +: SIDE_W]),
            .sel      ((s == 1) ? sel_tx_q : sel_rx_q),
            .atr_word ((s == 1) ? atr_tx_word : atr_rx_word),
            .dbg0     (dbg0[LO +: SIDE_W]),
            .dbg1     (dbg1[LO +: SIDE_W]),
            .pin_out  (pad_out[LO +: SIDE_W])
        );
    end

    // The output enables follow the direction register.
    assign pad_oe = dir_q;

    // Cycles since reset, so that the readback check never looks past reset.
    logic [1:0] warm_q;
    always_ff @(posedge clk) begin
        if (!rst_n)                warm_q <= '0;
        else if (warm_q != 2'd3)   warm_q <= warm_q + 2'd1;
    end

    AST_UNDRIVEN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_out & ~pad_oe) == '0); // R6

    AST_RD_PADS: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd3 && rd_addr == ADDR_W'(OFS_DATA)) |=>
            rd_data == $past(pad_in, 2)); // R9

endmodule

// File: tb/test_dbio_pin_ctrl.sv
`timescale 1ns/1ps
module test_dbio_pin_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [4:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        tx_active = 1'b0;
    logic        rx_active = 1'b0;
    logic [31:0] dbg0 = '0;
    logic [31:0] dbg1 = '0;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_out;
    logic [31:0] pad_oe;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    // Bench model of the registers, built from the requirements.
    logic [31:0] m_dir = '0, m_data = '0, m_selrx = '0, m_seltx = '0;
    logic [15:0] m_atr [8];
    logic [1:0]  m_st = '0;

    always #2.5 clk = ~clk;

    dbio_pin_ctrl i_dbio_pin_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .tx_active(tx_active), .rx_active(rx_active), .dbg0(dbg0),
        .dbg1(dbg1), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        case (a)
            5'h00: m_dir = d;
            5'h04: m_data = d;
            5'h08: m_selrx = d;
            5'h0C: m_seltx = d;
            default: if (a >= 5'h10 && !a[0]) m_atr[a[3:1]] = d[15:0];
        endcase
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] v);
        @(negedge clk); rd_addr = a;
        @(negedge clk);
        @(negedge clk); v = rd_data;
    endtask

    task automatic set_st(input logic [1:0] st);
        @(negedge clk); tx_active = st[0]; rx_active = st[1];
        @(negedge clk); m_st = st;
    endtask

    // Expected pad_out for radio state st.
    function automatic logic [31:0] exp_out(input logic [1:0] st);
        logic [31:0] e;
        for (int i = 0; i < 32; i++) begin
            bit          tx = (i >= 16);
            int          p  = i % 16;
            logic [1:0]  c  = tx ? m_seltx[2*p +: 2] : m_selrx[2*p +: 2];
            logic [15:0] w  = m_atr[{st, ~tx}];
            logic        v;
            case (c)
                2'd0: v = m_data[i];
                2'd1: v = w[p];
                2'd2: v = dbg0[i];
                default: v = dbg1[i];
            endcase
            e[i] = m_dir[i] & v;
        end
        return e;
    endfunction

    function automatic logic [31:0] sel_mix(input int off);
        logic [31:0] s;
        for (int p = 0; p < 16; p++) s[2*p +: 2] = 2'((p + off) % 4);
        return s;
    endfunction

    task automatic check_pads(input string tag);
        chk(tag, pad_out, exp_out(m_st));
        chk("R2 pad_oe", pad_oe, m_dir);
        chk("R6 undriven", pad_out & ~m_dir, 32'h0);
    endtask

    task automatic check_all_regs(input string tag);
        logic [31:0] v;
        rd(5'h00, v); chk({tag, " dir"}, v, m_dir);
        rd(5'h08, v); chk({tag, " sel rx"}, v, m_selrx);
        rd(5'h0C, v); chk({tag, " sel tx"}, v, m_seltx);
        for (int k = 0; k < 8; k++) begin
            rd(5'(16 + 2*k), v); chk({tag, " R8 word"}, v, {16'h0, m_atr[k]});
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [31:0] dirs [3];
        string       tag;
        for (int k = 0; k < 8; k++) m_atr[k] = '0;
        dirs[0] = 32'hFFFF_FFFF; dirs[1] = 32'hA5C3_0F0F; dirs[2] = 32'h0F0F_F0F0;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        @(negedge clk);
        chk("R1 pad_out", pad_out, 32'h0);
        chk("R1 pad_oe", pad_oe, 32'h0);
        chk("R1 rd_data", rd_data, 32'h0);
        rd(5'h04, v); chk("R1 pads", v, 32'h0);
        check_all_regs("R1");

        // R8: state word addresses; upper write bits ignored
        for (int k = 0; k < 8; k++)
            wr(5'(16 + 2*k), 32'hDEAD_0000 | {16'h0, 4'(k + 1), 12'h5A3 ^ 12'(k * 291)});
        check_all_regs("R8");

        // R10: register readback and ignored unmapped writes
        wr(5'h00, 32'hFFFF_FFFF);
        wr(5'h04, 32'h3C5A_96E1);
        wr(5'h08, sel_mix(1));
        wr(5'h0C, sel_mix(2));
        dbg0 = 32'h6789_ABCD; dbg1 = 32'hF0E1_D2C3;
        set_st(2'd2);
        check_pads("R10 before");
        wr(5'h11, 32'hFFFF_FFFF);
        wr(5'h01, 32'hFFFF_FFFF);
        wr(5'h06, 32'hFFFF_FFFF);
        wr(5'h1F, 32'hFFFF_FFFF);
        check_pads("R10 after unmapped writes");
        check_all_regs("R10");
        rd(5'h06, v); chk("R10 unmapped read", v, 32'h0);
        rd(5'h13, v); chk("R10 odd read", v, 32'h0);

        // Sweep: direction masks x select patterns x radio states
        for (int d = 0; d < 3; d++) begin
            wr(5'h00, dirs[d]);
            for (int sp = 0; sp < 6; sp++) begin
                if (sp < 4) begin
                    wr(5'h08, {16{2'(sp)}}); wr(5'h0C, {16{2'(sp)}});
                end else begin
                    wr(5'h08, sel_mix(sp == 4 ? 1 : 3));
                    wr(5'h0C, sel_mix(sp == 4 ? 0 : 2));
                end
                case (sp)
                    0: tag = "R3 data source";
                    1: tag = "R4 state source";
                    2, 3: tag = "R5 debug source";
                    default: tag = "R11 mixed select layout";
                endcase
                for (int st = 0; st < 4; st++) begin
                    set_st(2'(st));
                    check_pads(tag);
                end
            end
        end

        // R7: status change reaches pad_out only after the next edge
        wr(5'h00, 32'hFFFF_FFFF);
        wr(5'h08, {16{2'd1}}); wr(5'h0C, {16{2'd1}});
        set_st(2'd0);
        for (int st = 1; st < 4; st++) begin
            @(negedge clk); tx_active = st[0]; rx_active = st[1];
            #1 chk("R7 before edge", pad_out, exp_out(m_st));
            @(negedge clk); m_st = 2'(st);
            chk("R7 after edge", pad_out, exp_out(m_st));
        end

        // R9: pad readback, side halves and latency
        wr(5'h04, 32'h1234_4321);
        for (int k = 0; k < 4; k++) begin
            logic [31:0] pv = 32'h8E37_19C5 * (k + 3);
            pad_in = pv;
            rd(5'h04, v);
            chk("R9 pad readback", v, pv);
            chk("R9 transmit half", v >> 16, {16'h0, pv[31:16]});
            chk("R9 receive half", {16'h0, v[15:0]}, {16'h0, pv[15:0]});
        end
        @(negedge clk); rd_addr = 5'h04; v = pad_in; pad_in = 32'h0F1E_2D3C;
        @(negedge clk); chk("R9 one edge later old", rd_data, v);
        @(negedge clk); chk("R9 two edges later new", rd_data, 32'h0F1E_2D3C);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule